// File: doc/BRIEF.md
# Pulse-Wakeup Issue Queue

This block is the bank of waiting instructions that sits in front of one functional unit in an out-of-order core. Each entry holds an operation payload and up to two source operands. Each source operand is named by a physical register number. An operand is either ready when it is written into the bank, or it waits until the value for its register is produced.

Wakeup does not compare a broadcast tag against every entry. Instead, every physical register has its own wakeup line. A one-cycle pulse on line `p` tells the waiting operands that the value of register `p` will appear on one of several result buses in the following cycle. The bus that carries it is not fixed. In that following cycle, each flagged operand looks for its register number on the tag of every valid bus. It then takes the value, either by latching it or by issuing at once with the forwarded data.

Each cycle the bank selects one eligible entry, using only its own entries, and offers it to the unit through a valid/ready handshake. A parameter chooses the selection policy: rotating priority, which suits an arithmetic unit, or oldest first, which suits a branch unit.

Top module: `pulse_wake_iq`

## Requirements
- R1: After reset, or in the cycle after `flush` is high, no entry is held: `issue_valid` is 0 and `alloc_ready` is 1. An allocation presented in the same cycle as `flush` is discarded.
- R2: An entry is written when `alloc_valid` and `alloc_ready` are both high, into the lowest-numbered free slot. `alloc_ready` is low while all `ENTRIES` slots are occupied, and an allocation offered then is dropped.
- R3: An entry whose two operands are both marked ready at allocation is eligible for issue in the cycle after allocation, and it carries the values given at allocation.
- R4: A pulse on wakeup line `p` in cycle t flags every waiting operand named `p`. In cycle t+1 such an operand takes the data of a result bus `k` with `res_valid[k]` = 1 and tag field `res_tag[k*TAGW +: TAGW]` = `p`. If several buses match, the lowest-numbered bus is used. From then on the operand is ready.
- R5: Result-bus traffic for a register whose wakeup line did not pulse in the previous cycle is ignored, and the operand keeps waiting.
- R6: An operand that is not ready and is allocated in the same cycle as a pulse on its register's line is flagged exactly like an operand already held in the bank.
- R7: In the cycle its last missing value is on a result bus, an entry is already eligible, and it issues with the forwarded value in place of a stored one.
- R8: An entry leaves the bank in the cycle `issue_valid` and `issue_ready` are both high. While `issue_ready` is low, an offered entry remains offered.
- R9: With `OLDEST_FIRST` = 0, the search for an eligible entry starts at the slot after the last issued one and wraps around. After reset, the search starts at slot 0.
- R10: With `OLDEST_FIRST` = 1, the eligible entry that was allocated earliest is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drops every held entry |
| alloc_valid | input | 1 | New entry offered |
| alloc_ready | output | 1 | A free slot exists |
| alloc_op | input | OPW | Operation payload |
| alloc_a_tag | input | TAGW | Physical register of operand A |
| alloc_a_rdy | input | 1 | Operand A value already known |
| alloc_a_val | input | DW | Operand A value when known |
| alloc_b_tag | input | TAGW | Physical register of operand B |
| alloc_b_rdy | input | 1 | Operand B value already known |
| alloc_b_val | input | DW | Operand B value when known |
| wake_vec | input | PREGS | One wakeup line per physical register |
| res_valid | input | NBUS | Result bus k carries a value |
| res_tag | input | NBUS*TAGW | Register numbers, bus k at bits k*TAGW |
| res_data | input | NBUS*DW | Values, bus k at bits k*DW |
| issue_valid | output | 1 | An entry is offered to the unit |
| issue_ready | input | 1 | Unit accepts the offered entry |
| issue_slot | output | IW | Slot of the offered entry |
| issue_op | output | OPW | Payload of the offered entry |
| issue_a | output | DW | Operand A value |
| issue_b | output | DW | Operand B value |

## Verification
An allocation shows up at the issue port one cycle after its clock edge. A wakeup pulse in cycle t makes the entry eligible in cycle t+1, with the forwarded data on the issue port in that same cycle. It becomes a stored value from cycle t+2. The bench applies inputs just after a rising edge and samples at the falling edge of the cycle in which each result is due. A monitor pops the expected issue at every accepted handshake, so an issue that comes early, late or in the wrong order is caught. Two instances that differ only in selection policy receive the same stimulus, and each is checked against its own queue.

// File: rtl/pulse_wake_iq.sv
module pulse_wake_iq #(
  parameter int ENTRIES      = 4,
  parameter int PREGS        = 16,
  parameter int DW           = 16,
  parameter int OPW          = 8,
  parameter int NBUS         = 2,
  parameter bit OLDEST_FIRST = 1'b0,
  localparam int TAGW = (PREGS > 1) ? $clog2(PREGS) : 1,
  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 alloc_valid,
  output logic                 alloc_ready,
  input  logic [OPW-1:0]       alloc_op,
  input  logic [TAGW-1:0]      alloc_a_tag,
  input  logic                 alloc_a_rdy,
  input  logic [DW-1:0]        alloc_a_val,
  input  logic [TAGW-1:0]      alloc_b_tag,
  input  logic                 alloc_b_rdy,
  input  logic [DW-1:0]        alloc_b_val,
  input  logic [PREGS-1:0]     wake_vec,
  input  logic [NBUS-1:0]      res_valid,
  input  logic [NBUS*TAGW-1:0] res_tag,
  input  logic [NBUS*DW-1:0]   res_data,
  output logic                 issue_valid,
  input  logic                 issue_ready,
  output logic [IW-1:0]        issue_slot,
  output logic [OPW-1:0]       issue_op,
  output logic [DW-1:0]        issue_a,
  output logic [DW-1:0]        issue_b
);

  logic [ENTRIES-1:0] vld;
  logic [OPW-1:0]     op_q  [ENTRIES];
  logic [TAGW-1:0]    tag_q [ENTRIES][2];
  logic [DW-1:0]      val_q [ENTRIES][2];
  logic [1:0]         rdy_q [ENTRIES];
  logic [1:0]         pend_q[ENTRIES];
  logic [ENTRIES-1:0] older [ENTRIES];
  logic [IW-1:0]      ptr;

  logic [1:0]         hit   [ENTRIES];
  logic [DW-1:0]      hval  [ENTRIES][2];
  logic [1:0]         eff_rdy[ENTRIES];
  logic [DW-1:0]      eff_val[ENTRIES][2];
  logic [ENTRIES-1:0] elig;
  logic [IW-1:0]      sel, afree;
  logic               issue_fire, alloc_fire;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      for (int s = 0; s < 2; s++) begin
        hit[i][s]  = 1'b0;
        hval[i][s] = '0;
        for (int k = NBUS - 1; k >= 0; k--) begin
          if (pend_q[i][s] && res_valid[k] && res_tag[k*TAGW +: TAGW] == tag_q[i][s]) begin
            hit[i][s]  = 1'b1;
            hval[i][s] = res_data[k*DW +: DW];
          end
        end
        eff_rdy[i][s] = rdy_q[i][s] | hit[i][s];
        eff_val[i][s] = rdy_q[i][s] ? val_q[i][s] : hval[i][s];
      end
      elig[i] = vld[i] & (&eff_rdy[i]);
    end
  end

  always_comb begin
    logic found, blocked;
    sel   = '0;
    found = 1'b0;
    if (OLDEST_FIRST) begin
      for (int i = 0; i < ENTRIES; i++) begin
        blocked = 1'b0;
        for (int j = 0; j < ENTRIES; j++)
          if (j != i && elig[j] && older[j][i]) blocked = 1'b1;
        if (!found && elig[i] && !blocked) begin
          sel   = IW'(i);
          found = 1'b1;
        end
      end
    end else begin
      for (int k = 0; k < ENTRIES; k++) begin
        int idx;
        idx = (int'(ptr) + 1 + k) % ENTRIES;
        if (!found && elig[idx]) begin
          sel   = IW'(idx);
          found = 1'b1;
        end
      end
    end
  end

  always_comb begin
    afree = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) afree = IW'(i);
  end

  assign alloc_ready = ~&vld;
  assign alloc_fire  = alloc_valid & alloc_ready & ~flush;
  assign issue_valid = |elig;
  assign issue_fire  = issue_valid & issue_ready;
  assign issue_slot  = sel;
  assign issue_op    = op_q[sel];
  assign issue_a     = eff_val[sel][0];
  assign issue_b     = eff_val[sel][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= IW'(ENTRIES - 1);
      for (int i = 0; i < ENTRIES; i++) begin
        pend_q[i] <= '0;
        rdy_q[i]  <= '0;
        older[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int s = 0; s < 2; s++) begin
          if (hit[i][s]) begin
            rdy_q[i][s] <= 1'b1;
            val_q[i][s] <= hval[i][s];
          end
          pend_q[i][s] <= ~rdy_q[i][s] & ~hit[i][s] & wake_vec[tag_q[i][s]];
        end
      end
      if (issue_fire) begin
        vld[sel] <= 1'b0;
        ptr      <= sel;
      end
      if (alloc_fire) begin
        vld[afree]      <= 1'b1;
        op_q[afree]     <= alloc_op;
        tag_q[afree][0] <= alloc_a_tag;
        tag_q[afree][1] <= alloc_b_tag;
        val_q[afree][0] <= alloc_a_val;
        val_q[afree][1] <= alloc_b_val;
        rdy_q[afree]    <= {alloc_b_rdy, alloc_a_rdy};
        pend_q[afree]   <= {~alloc_b_rdy & wake_vec[alloc_b_tag],
                            ~alloc_a_rdy & wake_vec[alloc_a_tag]};
        for (int j = 0; j < ENTRIES; j++) older[j][afree] <= 1'b1;
        older[afree] <= '0;
      end
      if (flush) vld <= '0;
    end
  end

  // R1
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!issue_valid && alloc_ready));

  // R2
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !flush && !issue_fire)
      |=> $countones(vld) == $past($countones(vld)) + 1);

  // R8
  issue_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && !flush) |=> !vld[$past(issue_slot)]);

  // R8
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready && !flush) |=> issue_valid);

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !issue_fire && !flush) |=> $stable(vld));

endmodule

// File: tb/pulse_wake_iq_test.sv
`timescale 1ns/1ps
module pulse_wake_iq_test;
  localparam int ENTRIES = 4, PREGS = 16, DW = 16, OPW = 8, NBUS = 2;
  localparam int TAGW = 4, IW = 2;

  logic clk = 1'b0;
  logic rst_n, flush, alloc_valid, issue_ready;
  logic [OPW-1:0] alloc_op;
  logic [TAGW-1:0] alloc_a_tag, alloc_b_tag;
  logic alloc_a_rdy, alloc_b_rdy;
  logic [DW-1:0] alloc_a_val, alloc_b_val;
  logic [PREGS-1:0] wake_vec;
  logic [NBUS-1:0] res_valid;
  logic [NBUS*TAGW-1:0] res_tag;
  logic [NBUS*DW-1:0] res_data;

  logic ar_rr, iv_rr, ar_ag, iv_ag;
  logic [IW-1:0] sl_rr, sl_ag;
  logic [OPW-1:0] op_rr, op_ag;
  logic [DW-1:0] a_rr, b_rr, a_ag, b_ag;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R3";
  logic [OPW+2*DW-1:0] q_rr[$], q_ag[$];

  always #2.5 clk = ~clk;

  pulse_wake_iq #(.ENTRIES(ENTRIES), .PREGS(PREGS), .DW(DW), .OPW(OPW), .NBUS(NBUS),
                  .OLDEST_FIRST(1'b0)) uut (
    .clk, .rst_n, .flush, .alloc_valid, .alloc_ready(ar_rr), .alloc_op,
    .alloc_a_tag, .alloc_a_rdy, .alloc_a_val, .alloc_b_tag, .alloc_b_rdy, .alloc_b_val,
    .wake_vec, .res_valid, .res_tag, .res_data,
    .issue_valid(iv_rr), .issue_ready, .issue_slot(sl_rr), .issue_op(op_rr),
    .issue_a(a_rr), .issue_b(b_rr));

  pulse_wake_iq #(.ENTRIES(ENTRIES), .PREGS(PREGS), .DW(DW), .OPW(OPW), .NBUS(NBUS),
                  .OLDEST_FIRST(1'b1)) uut_age (
    .clk, .rst_n, .flush, .alloc_valid, .alloc_ready(ar_ag), .alloc_op,
    .alloc_a_tag, .alloc_a_rdy, .alloc_a_val, .alloc_b_tag, .alloc_b_rdy, .alloc_b_val,
    .wake_vec, .res_valid, .res_tag, .res_data,
    .issue_valid(iv_ag), .issue_ready, .issue_slot(sl_ag), .issue_op(op_ag),
    .issue_a(a_ag), .issue_b(b_ag));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && issue_ready && iv_rr) begin
      checks++;
      if (q_rr.size() == 0) begin
        fails++;
        $display("FAIL %s rotating: actual %0h expected none", cur_req, {op_rr, a_rr, b_rr});
      end else begin
        logic [OPW+2*DW-1:0] e;
        e = q_rr.pop_front();
        if ({op_rr, a_rr, b_rr} != e) begin
          fails++;
          $display("FAIL %s rotating: actual %0h expected %0h", cur_req, {op_rr, a_rr, b_rr}, e);
        end
      end
    end
    if (rst_n && issue_ready && iv_ag) begin
      checks++;
      if (q_ag.size() == 0) begin
        fails++;
        $display("FAIL %s oldest: actual %0h expected none", cur_req, {op_ag, a_ag, b_ag});
      end else begin
        logic [OPW+2*DW-1:0] e;
        e = q_ag.pop_front();
        if ({op_ag, a_ag, b_ag} != e) begin
          fails++;
          $display("FAIL %s oldest: actual %0h expected %0h", cur_req, {op_ag, a_ag, b_ag}, e);
        end
      end
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic idle();
    alloc_valid = 0; wake_vec = '0; res_valid = '0; res_tag = '0; res_data = '0; flush = 0;
  endtask

  task automatic alloc(int op, int at, bit ar, int av, int bt, bit br, int bv);
    alloc_valid = 1; alloc_op = OPW'(op);
    alloc_a_tag = TAGW'(at); alloc_a_rdy = ar; alloc_a_val = DW'(av);
    alloc_b_tag = TAGW'(bt); alloc_b_rdy = br; alloc_b_val = DW'(bv);
  endtask

  task automatic bus(int k, int tag, int data);
    res_valid[k] = 1'b1;
    res_tag[k*TAGW +: TAGW] = TAGW'(tag);
    res_data[k*DW +: DW] = DW'(data);
  endtask

  function automatic logic [OPW+2*DW-1:0] item(int op, int a, int b);
    return {OPW'(op), DW'(a), DW'(b)};
  endfunction

  task automatic do_reset();
    rst_n = 0; idle(); issue_ready = 0;
    repeat (3) cyc();
    rst_n = 1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    alloc_op = '0; alloc_a_tag = '0; alloc_b_tag = '0; alloc_a_rdy = 0; alloc_b_rdy = 0;
    alloc_a_val = '0; alloc_b_val = '0;
    do_reset();
    @(negedge clk);
    chk("R1 reset alloc_ready", ar_rr, 1); chk("R1 reset issue_valid", iv_rr, 0);
    chk("R1 reset oldest issue_valid", iv_ag, 0);

    // R3: ready at allocation
    cur_req = "R3"; cyc();
    alloc(1, 0, 1, 10, 0, 1, 20); cyc(); idle();
    q_rr.push_back(item(1, 10, 20)); q_ag.push_back(item(1, 10, 20));
    issue_ready = 1; @(negedge clk);
    chk("R3 eligible after alloc", iv_rr, 1);
    cyc(); issue_ready = 0; @(negedge clk);
    chk("R8 entry freed", iv_rr, 0);

    // R4, R7: pulse then bus0
    cur_req = "R4"; cyc();
    alloc(2, 5, 0, 0, 0, 1, 7); cyc(); idle();
    @(negedge clk); chk("R4 waiting", iv_rr, 0);
    cyc(); wake_vec[5] = 1; cyc(); idle(); bus(0, 5, 55);
    @(negedge clk);
    chk("R7 bypass eligible", iv_rr, 1); chk("R7 bypass value", a_rr, 55);
    cyc(); idle(); @(negedge clk);
    chk("R8 held while stalled", iv_rr, 1); chk("R4 captured value", a_rr, 55);
    q_rr.push_back(item(2, 55, 7)); q_ag.push_back(item(2, 55, 7));
    cyc(); issue_ready = 1; cyc(); issue_ready = 0;

    // R5: bus without pulse; R1: flush beats alloc
    alloc(3, 6, 0, 0, 0, 1, 1); cyc(); idle(); bus(0, 6, 66); cyc(); idle();
    @(negedge clk); chk("R5 unflagged bus ignored", iv_rr, 0);
    cyc(); flush = 1; alloc(4, 0, 1, 1, 0, 1, 1); cyc(); idle();
    @(negedge clk);
    chk("R1 flush issue_valid", iv_rr, 0); chk("R1 flush alloc_ready", ar_rr, 1);
    cyc(); wake_vec[6] = 1; cyc(); idle(); bus(0, 6, 66);
    @(negedge clk); chk("R1 flushed entry gone", iv_rr, 0);

    // R6, R7: alloc with same-cycle pulse, value on bus1
    cur_req = "R6"; cyc(); idle();
    alloc(5, 0, 1, 3, 9, 0, 0); wake_vec[9] = 1; cyc(); idle();
    bus(0, 2, 'h22); bus(1, 9, 99);
    q_rr.push_back(item(5, 3, 99)); q_ag.push_back(item(5, 3, 99));
    issue_ready = 1; @(negedge clk);
    chk("R6 same-cycle pulse seen", iv_rr, 1);
    cyc(); idle(); issue_ready = 0;

    // R2: fill, refuse fifth; R9/R10 order
    cur_req = "R2";
    for (int i = 0; i < 4; i++) begin alloc(20 + i, 12, 0, 0, 12, 0, 0); cyc(); end
    idle(); @(negedge clk); chk("R2 full alloc_ready", ar_rr, 0);
    cyc(); alloc(24, 0, 1, 4, 0, 1, 4); cyc(); idle();
    wake_vec[12] = 1; cyc(); idle(); bus(0, 12, 'hC);
    cur_req = "R9";
    foreach (q_rr[i]) ;
    q_rr.push_back(item(21, 'hC, 'hC)); q_rr.push_back(item(22, 'hC, 'hC));
    q_rr.push_back(item(23, 'hC, 'hC)); q_rr.push_back(item(20, 'hC, 'hC));
    for (int i = 0; i < 4; i++) q_ag.push_back(item(20 + i, 'hC, 'hC));
    issue_ready = 1;
    repeat (4) cyc();
    idle(); @(negedge clk); chk("R2 dropped fifth alloc", iv_rr, 0);
    cyc(); issue_ready = 0;
    chk("R9 rotating queue drained", q_rr.size(), 0);
    chk("R10 oldest queue drained", q_ag.size(), 0);

    // R9, R10: policies diverge after reset
    do_reset(); cur_req = "R10";
    alloc(30, 3, 0, 0, 0, 1, 31); cyc();
    alloc(31, 0, 1, 31, 0, 1, 32); cyc();
    alloc(32, 0, 1, 32, 0, 1, 33); cyc();
    alloc(33, 0, 1, 33, 0, 1, 34); cyc(); idle();
    q_rr.push_back(item(31, 31, 32)); q_ag.push_back(item(31, 31, 32));
    issue_ready = 1; cyc(); issue_ready = 0;
    alloc(34, 0, 1, 34, 0, 1, 35); cyc(); idle();
    wake_vec[3] = 1; cyc(); idle(); bus(0, 3, 'h30); cyc(); idle();
    q_rr.push_back(item(32, 32, 33)); q_rr.push_back(item(33, 33, 34));
    q_rr.push_back(item(30, 'h30, 31)); q_rr.push_back(item(34, 34, 35));
    q_ag.push_back(item(30, 'h30, 31)); q_ag.push_back(item(32, 32, 33));
    q_ag.push_back(item(33, 33, 34)); q_ag.push_back(item(34, 34, 35));
    issue_ready = 1; repeat (4) cyc(); issue_ready = 0;
    @(negedge clk);
    chk("R9 rotating order complete", q_rr.size(), 0);
    chk("R10 age order complete", q_ag.size(), 0);
    chk("R8 bank empty after issues", iv_ag, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule